// File: doc/BRIEF.md
# Clock Mode and Standby Controller

This block sets how a small microcontroller is clocked. It has two clock sources. The fast main oscillator runs the block's own clock domain. A slow subclock, nominally 32.768 kHz, arrives as a one-cycle tick pulse per subclock period. Each oscillator is modelled as a digital pair: the block drives an enable, and the oscillator model answers with a valid flag once it is stable. The block writes three control registers through a simple write port:

- the processor clock register, which holds the divide select and the main-stop bit;
- the sub-oscillator mode register, which holds the sub-stop bit and the feedback-resistor disable;
- the clock source register, which holds the subclock select.

From these registers the block drives the CPU clock enable. This is a one-cycle pulse per CPU cycle, taken from the main clock divided by 2 or by 8, or from the subclock divided by 4. The block also gives a peripheral tick, a divided main clock that stops whenever the main oscillator is stopped. It passes the subclock through as a feed for always-on peripherals, and that feed keeps running in standby.

The block handles the two standby states, HALT and STOP, and leaves both on an interrupt. It enforces the rules between its registers:

- the main oscillator may be stopped only while the subclock runs the CPU;
- STOP is refused while the subclock is the CPU source;
- a write that would stop the oscillator feeding the CPU, or its selected target, is rejected, and the register bit keeps its old value.

A change of CPU source takes place only at the end of a CPU cycle, and only once the target oscillator reports valid.

Top module: `clock_mode_ctrl`

## Requirements
- R1: During reset, mainOscEn is 0, srcIsSub is 0, and halted and stopped are 0. After reset the processor clock register holds 0x02 (bit 1 = 1), which gives slow main mode, and mainOscEn becomes 1.
- R2: With the main clock as source, cpuEn pulses once every FAST_DIV clk cycles when processor clock bit 1 is 0, and once every SLOW_DIV cycles when it is 1. With the subclock as source, cpuEn pulses once every SUB_DIV subTick pulses.
- R3: Clock source register (wrSel=2) bit 4 selects the subclock as CPU source. The switch happens only on a CPU-cycle boundary and only while the target oscillator is enabled and valid. srcIsSub reports the source in use.
- R4: Processor clock register (wrSel=0) bit 7 = 1 stops the main oscillator. A write of bit 7 = 1 while the main clock is the CPU source is rejected: the bit keeps its old value, and mainOscEn stays 1 after a later switch to the subclock.
- R5: Sub-oscillator mode register (wrSel=1) bit 0 = 1 clears subOscEn. This write is rejected while the subclock is the source or is selected. Bit 1 = 1 drives fbResEn to 0. A write of clock source register bit 4 = 1 is rejected while the sub oscillator is stopped.
- R6: haltReq enters HALT with either source. While halted, cpuEn stays 0. irq leaves HALT on the next edge, with no settle delay.
- R7: stopReq enters STOP only while the main clock is the CPU source, and is ignored otherwise. In STOP, mainOscEn and cpuEn are 0.
- R8: irq leaves STOP. mainOscEn is enabled again, and cpuEn stays 0 for at least SETTLE_CYC clk cycles after the exit edge.
- R9: periTick pulses once every PERI_DIV clk cycles while the main oscillator is enabled and valid, and does not pulse while it is stopped.
- R10: subFeed repeats subTick while the sub oscillator is enabled and valid, including during HALT and STOP, and is 0 while the sub oscillator is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 processor clock, 1 sub-oscillator mode, 2 clock source |
| wrData | input | 8 | Write data |
| haltReq | input | 1 | Request to enter HALT |
| stopReq | input | 1 | Request to enter STOP |
| irq | input | 1 | Interrupt that ends standby |
| subTick | input | 1 | One pulse per subclock period |
| mainOscValid | input | 1 | Main oscillator is stable |
| subOscValid | input | 1 | Sub oscillator is stable |
| mainOscEn | output | 1 | Main oscillator enable |
| subOscEn | output | 1 | Sub oscillator enable |
| fbResEn | output | 1 | Feedback resistor enable |
| cpuEn | output | 1 | CPU clock enable, one pulse per CPU cycle |
| periTick | output | 1 | Divided main clock for peripherals |
| subFeed | output | 1 | Subclock pulses for always-on peripherals |
| srcIsSub | output | 1 | The subclock is the CPU source |
| halted | output | 1 | HALT state |
| stopped | output | 1 | STOP state |

## Verification
The bench builds the block with SETTLE_CYC = 20 and PERI_DIV = 4, and keeps the default divide ratios of 2, 8 and 4. It drives a subclock tick every 6 cycles, so one subclock CPU cycle lasts 24 clk cycles. With these values the settle window after STOP, every divide ratio and the source switches in both directions all fit into a few hundred cycles. That makes the boundary-aligned switch and the write-rejection rules directly observable at the ports.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef struct packed {
    logic mainRun;   // main oscillator enabled and valid
    logic subRun;    // sub oscillator enabled and valid
    logic useSub;    // CPU source in use is the subclock
    logic slowMode;  // main clock uses the slow divide
    logic gateCpu;   // suppress CPU enable (standby or settle)
  } ctlStrobe_t;
endpackage

// File: rtl/clkctl_datapath.sv
module clkctl_datapath
  import clkctl_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 8,
  parameter int SUB_DIV  = 4,
  parameter int PERI_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subTick,
  input  ctlStrobe_t ctl,
  output logic       atBoundary,
  output logic       cpuEn,
  output logic       periTick,
  output logic       subFeed
);
  localparam int MAX_MAIN = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int MAX_DIV  = (SUB_DIV > MAX_MAIN) ? SUB_DIV : MAX_MAIN;
  localparam int CW       = $clog2(MAX_DIV + 1);

  logic          srcTick;
  logic [CW-1:0] cycCnt;
  logic [CW-1:0] term;

  assign srcTick = ctl.useSub ? (ctl.subRun && subTick) : ctl.mainRun;

  always_comb begin
    if (ctl.useSub)        term = CW'(SUB_DIV - 1);
    else if (ctl.slowMode) term = CW'(SLOW_DIV - 1);
    else                   term = CW'(FAST_DIV - 1);
  end

  assign atBoundary = srcTick && (cycCnt >= term);
  assign cpuEn      = atBoundary && !ctl.gateCpu;
  assign subFeed    = ctl.subRun && subTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cycCnt <= '0;
    else if (srcTick) cycCnt <= atBoundary ? '0 : cycCnt + 1'b1;
  end

  generate
    if (PERI_DIV <= 1) begin : g_periDirect
      assign periTick = ctl.mainRun;
    end else begin : g_periCount
      localparam int PW = $clog2(PERI_DIV);
      logic [PW-1:0] periCnt;
      logic          periWrap;
      assign periWrap = (periCnt == PW'(PERI_DIV - 1));
      assign periTick = ctl.mainRun && periWrap;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            periCnt <= '0;
        else if (ctl.mainRun) periCnt <= periWrap ? '0 : periCnt + 1'b1;
      end
    end
  endgenerate

  // R9
  peri_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.mainRun |-> !periTick);
  // R10
  feed_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.subRun |-> !subFeed);
endmodule

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter int SETTLE_CYC = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [7:0] wrData,
  input  logic       haltReq,
  input  logic       stopReq,
  input  logic       irq,
  input  logic       mainOscValid,
  input  logic       subOscValid,
  input  logic       atBoundary,
  input  logic       cpuEn,
  output ctlStrobe_t ctl,
  output logic       mainOscEn,
  output logic       subOscEn,
  output logic       fbResEn,
  output logic       srcIsSub,
  output logic       halted,
  output logic       stopped
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic          pccStopMain, pccSlow;
  logic          somStopSub, somFbOff;
  logic          selSub, curSrcSub;
  logic [SW-1:0] settleCnt;
  logic          wrPcc, wrSom, wrSrc;
  logic          mainRun, subRun, targetRun;
  logic          unusedWrBits;

  assign unusedWrBits = ^{wrData[6:5], wrData[3:2]};

  assign wrPcc = wrEn && (wrSel == 2'd0);
  assign wrSom = wrEn && (wrSel == 2'd1);
  assign wrSrc = wrEn && (wrSel == 2'd2);

  assign mainOscEn = rstN && !stopped && !(pccStopMain && selSub && curSrcSub);
  assign subOscEn  = !somStopSub;
  assign fbResEn   = !somFbOff;
  assign mainRun   = mainOscEn && mainOscValid;
  assign subRun    = subOscEn && subOscValid;
  assign targetRun = selSub ? subRun : mainRun;
  assign srcIsSub  = curSrcSub;

  assign ctl.mainRun  = mainRun;
  assign ctl.subRun   = subRun;
  assign ctl.useSub   = curSrcSub;
  assign ctl.slowMode = pccSlow;
  assign ctl.gateCpu  = halted || stopped || (settleCnt != '0);

  // register writes with the rejection rules
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pccStopMain <= 1'b0;
      pccSlow     <= 1'b1;
      somStopSub  <= 1'b0;
      somFbOff    <= 1'b0;
      selSub      <= 1'b0;
    end else begin
      if (wrPcc) begin
        pccSlow     <= wrData[1];
        pccStopMain <= wrData[7] ? (curSrcSub ? 1'b1 : pccStopMain) : 1'b0;
      end
      if (wrSom) begin
        somFbOff   <= wrData[1];
        somStopSub <= wrData[0] ? ((selSub || curSrcSub) ? somStopSub : 1'b1) : 1'b0;
      end
      if (wrSrc) begin
        selSub <= wrData[4] ? (somStopSub ? selSub : 1'b1) : 1'b0;
      end
    end
  end

  // source switch at a cycle boundary once the target is valid
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curSrcSub <= 1'b0;
    else if (atBoundary && (selSub != curSrcSub) && targetRun) curSrcSub <= selSub;
  end

  // standby states and settle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halted    <= 1'b0;
      stopped   <= 1'b0;
      settleCnt <= '0;
    end else begin
      if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
      if (halted) begin
        if (irq) halted <= 1'b0;
      end else if (stopped) begin
        if (irq) begin
          stopped   <= 1'b0;
          settleCnt <= SW'(SETTLE_CYC);
        end
      end else if (stopReq && !curSrcSub) begin
        stopped <= 1'b1;
      end else if (haltReq) begin
        halted <= 1'b1;
      end
    end
  end

  // R7
  stop_mainoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> !mainOscEn);
  // R7
  stop_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && curSrcSub && !halted && !stopped) |=> !stopped);
  // R6
  standby_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted || stopped) |-> !cpuEn);
  // R8
  settle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (settleCnt != '0) |-> !cpuEn);
  // R3
  switch_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curSrcSub != $past(curSrcSub)) |-> $past(atBoundary));
  // R5
  sub_feeding_chk: assert property (@(posedge clk) disable iff (!rstN)
    curSrcSub |-> subOscEn);
  // R6
  halt_stop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(halted && stopped));
endmodule

// File: rtl/clock_mode_ctrl.sv
module clock_mode_ctrl
  import clkctl_pkg::*;
#(
  parameter int FAST_DIV   = 2,
  parameter int SLOW_DIV   = 8,
  parameter int SUB_DIV    = 4,
  parameter int PERI_DIV   = 4,
  parameter int SETTLE_CYC = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [7:0] wrData,
  input  logic       haltReq,
  input  logic       stopReq,
  input  logic       irq,
  input  logic       subTick,
  input  logic       mainOscValid,
  input  logic       subOscValid,
  output logic       mainOscEn,
  output logic       subOscEn,
  output logic       fbResEn,
  output logic       cpuEn,
  output logic       periTick,
  output logic       subFeed,
  output logic       srcIsSub,
  output logic       halted,
  output logic       stopped
);
  ctlStrobe_t ctl;
  logic       atBoundary;

  clkctl_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .haltReq(haltReq), .stopReq(stopReq), .irq(irq),
    .mainOscValid(mainOscValid), .subOscValid(subOscValid),
    .atBoundary(atBoundary), .cpuEn(cpuEn), .ctl(ctl),
    .mainOscEn(mainOscEn), .subOscEn(subOscEn), .fbResEn(fbResEn),
    .srcIsSub(srcIsSub), .halted(halted), .stopped(stopped)
  );

  clkctl_datapath #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .SUB_DIV(SUB_DIV), .PERI_DIV(PERI_DIV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .subTick(subTick), .ctl(ctl),
    .atBoundary(atBoundary), .cpuEn(cpuEn), .periTick(periTick), .subFeed(subFeed)
  );
endmodule

// File: tb/clock_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clock_mode_ctrl_tb;
  localparam int SETTLE = 20;
  localparam int PDIV   = 4;
  localparam int SUBP   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic haltReq = 1'b0, stopReq = 1'b0, irq = 1'b0;
  logic subTick, mainOscValid, subOscValid;
  logic mainOscEn, subOscEn, fbResEn, cpuEn, periTick, subFeed, srcIsSub, halted, stopped;
  logic [2:0] mainSh = '0, subSh = '0;
  int subCnt = 0;
  int checks = 0, errors = 0;
  int cyc = 0, lastPulse = 0;
  int expQ[$];
  string tagQ[$];
  event pulseEv;

  always #5 clk = ~clk;

  // oscillator and subclock models
  always @(posedge clk) begin
    mainSh <= {mainSh[1:0], mainOscEn};
    subSh  <= {subSh[1:0], subOscEn};
    subCnt <= (subCnt == SUBP - 1) ? 0 : subCnt + 1;
  end
  assign mainOscValid = (&mainSh) && mainOscEn;
  assign subOscValid  = (&subSh) && subOscEn;
  assign subTick      = (subCnt == SUBP - 1);

  clock_mode_ctrl #(.PERI_DIV(PDIV), .SETTLE_CYC(SETTLE)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compares CPU-cycle intervals against the expected queue
  always @(negedge clk) begin
    cyc++;
    if (cpuEn) begin
      if (expQ.size() > 0) begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check((cyc - lastPulse) == e, t, cyc - lastPulse, e);
      end
      lastPulse = cyc;
      ->pulseEv;
    end
  end

  task automatic expectPeriod(input int e, input string tag);
    @pulseEv;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @pulseEv;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic countOver(input int n, ref logic sig, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sig) cnt++;
    end
  endtask

  task automatic waitSrc(input logic want);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (srcIsSub == want) break;
    end
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(mainOscEn == 1'b0, "R1 mainOscEn in reset", mainOscEn, 0);
    check(srcIsSub == 1'b0 && halted == 1'b0 && stopped == 1'b0, "R1 status in reset",
          {srcIsSub, halted, stopped}, 0);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
    check(mainOscEn == 1'b1, "R1 mainOscEn after reset", mainOscEn, 1);
    expectPeriod(8, "R1 slow default period");

    // R2 fast main
    wr(2'd0, 8'h00);
    expectPeriod(2, "R2 fast period");
    // R9 peripheral tick rate
    countOver(40, periTick, n);
    check(n == 40 / PDIV, "R9 periTick count", n, 40 / PDIV);

    // R4 stop-main write rejected while main is source
    wr(2'd0, 8'h80);
    check(mainOscEn == 1'b1, "R4 reject keeps main", mainOscEn, 1);

    // R3 switch to subclock
    wr(2'd2, 8'h10);
    waitSrc(1'b1);
    check(srcIsSub == 1'b1, "R3 switched to sub", srcIsSub, 1);
    check(mainOscEn == 1'b1, "R4 rejected bit stayed clear", mainOscEn, 1);
    expectPeriod(4 * SUBP, "R2 sub period");

    // R4 stop main while sub is source
    wr(2'd0, 8'h80);
    check(mainOscEn == 1'b0, "R4 main stopped", mainOscEn, 0);
    countOver(40, periTick, n);
    check(n == 0, "R9 no periTick while main stopped", n, 0);

    // R5 sub stop rejected, feedback disable
    wr(2'd1, 8'h01);
    check(subOscEn == 1'b1, "R5 sub stop rejected", subOscEn, 1);
    wr(2'd1, 8'h02);
    check(fbResEn == 1'b0 && subOscEn == 1'b1, "R5 fbResEn off", {fbResEn, subOscEn}, 1);

    // R7 STOP ignored on subclock
    pulse(stopReq);
    @(negedge clk);
    check(stopped == 1'b0, "R7 stop ignored on sub", stopped, 0);
    expectPeriod(4 * SUBP, "R7 cpu still running");

    // R6 HALT on subclock, R10 feed continues
    pulse(haltReq);
    check(halted == 1'b1, "R6 halted on sub", halted, 1);
    countOver(60, cpuEn, n);
    check(n == 0, "R6 no cpuEn in halt", n, 0);
    countOver(60, subFeed, n);
    check(n == 60 / SUBP, "R10 subFeed in halt", n, 60 / SUBP);
    pulse(irq);
    check(halted == 1'b0, "R6 halt exit", halted, 1'b0);
    expectPeriod(4 * SUBP, "R6 resume period");

    // R3 back to main
    wr(2'd2, 8'h00);
    waitSrc(1'b0);
    check(srcIsSub == 1'b0 && mainOscEn == 1'b1, "R3 back to main", {srcIsSub, mainOscEn}, 1);
    wr(2'd0, 8'h02);
    expectPeriod(8, "R2 slow period");

    // R7 STOP on main
    pulse(stopReq);
    check(stopped == 1'b1 && mainOscEn == 1'b0, "R7 stop entered", {stopped, mainOscEn}, 2);
    countOver(30, cpuEn, n);
    check(n == 0, "R7 no cpuEn in stop", n, 0);
    countOver(60, subFeed, n);
    check(n == 60 / SUBP, "R10 subFeed in stop", n, 60 / SUBP);

    // R8 exit and settle
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    check(stopped == 1'b0 && mainOscEn == 1'b1, "R8 stop exit", {stopped, mainOscEn}, 1);
    n = 1;
    while (!cpuEn && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n > SETTLE && n <= SETTLE + 14, "R8 settle delay", n, SETTLE + 1);

    // R5 stop sub oscillator while main runs; select sub rejected
    wr(2'd1, 8'h01);
    check(subOscEn == 1'b0, "R5 sub stopped", subOscEn, 0);
    countOver(30, subFeed, n);
    check(n == 0, "R10 no subFeed when stopped", n, 0);
    wr(2'd2, 8'h10);
    repeat (100) @(negedge clk);
    check(srcIsSub == 1'b0, "R5 select sub rejected", srcIsSub, 0);

    finishRun();
  end
endmodule